// File: doc/BRIEF.md
# Hardware Page Table Walker

This block turns one 64-bit virtual address at a time into a real page address. A request brings the virtual address, the kind of access (read, write or instruction fetch), a 2-bit address-space mode and a translation-enable flag. The mode picks one of three control-register inputs as the top translation descriptor. The descriptor's type field fixes how deep the walk goes: up to three upper region tables, then a region table that points at a segment table, a segment table, and a page table. Every table entry is a 64-bit word fetched through a read port with a valid/ready request side and a valid-only response side.

A walk ends with a response held on a valid/ready output. The response carries either a page-aligned real address with read, write and execute permission bits, or a fault code and an exception word. The request side is valid/ready. `req_ready` is high only while no walk is in flight, so a new request waits until the previous response has been taken. `rsp_valid` stays high with stable contents until `rsp_ready` is seen at a clock edge. The memory read request keeps its address stable until `mem_rd_ready` is seen. The walker never issues a second read before the data of the first has arrived. The three control-register inputs must be held stable while `busy` is high.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. `busy` rises in the cycle after a request is accepted and falls in the cycle after a response is taken with `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.
- R2: When `req_xlate_en` is 0, the response carries fault 0, the real address equal to the virtual address with bits 11..0 cleared, and read, write and execute all 1. No memory read is issued and the mode is not examined.
- R3: Mode 2'b00 (primary) selects `cr_primary`, mode 2'b10 (secondary) selects `cr_secondary` and mode 2'b11 (home) selects `cr_home`. Mode 2'b01 gives fault 5 with no memory read, and its exception word is the page-aligned virtual address.
- R4: The descriptor type field (bits 3..2) limits the address range. Type 2 needs virtual bits 63..53 to be zero, type 1 needs bits 63..42 to be zero, and type 0 needs bits 63..31 to be zero; type 3 has no limit. A violation gives fault 1 (specification) with no memory read.
- R5: A descriptor with bit 5 set maps the page-aligned virtual address straight to the real address, with no memory read. The permission bits are still adjusted as R10 requires.
- R6: A walk with descriptor type T reads T+2 entries. Table kind k (3, 2, 1, then 0 for the segment table) is indexed by virtual bits [63:53], [52:42], [41:31] and [30:20] for k = 3, 2, 1 and 0; the page table is indexed by bits [19:12]. Each read address is the table origin plus the index times 8.
- R7: An entry read from a table of kind k with bit 5 set gives fault 2 (segment translation). Otherwise, an entry whose bits 3..2 differ from k gives fault 1. The invalid bit is checked first.
- R8: The table origin is bits 63..12 of the descriptor or of a region entry, and bits 63..11 of a segment entry.
- R9: A page entry with bit 10 set gives fault 3 (page translation). Otherwise the real address is entry bits 63..12, and entry bit 9 (read-only) clears write permission.
- R10: In secondary mode, a fetch walks the primary space and is granted execute only. A read or write walks the secondary space and loses execute permission.
- R11: A write to a read-only page gives fault 4 (protection). For faults 1 to 4 the exception word is the page-aligned virtual address OR'd with the space code of the space walked (primary 1, secondary 2, home 3). A protection fault also sets bit 2 of the word.
- R12: A faulting response has real address 0 and all permission bits 0; a successful response has exception word 0. Access code 2'b11 behaves exactly like a read (2'b00 read, 2'b01 write, 2'b10 fetch).
- R13: `mem_rd_valid` and `mem_rd_addr` hold until `mem_rd_ready` is seen, and every read address is 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 treated as read |
| req_mode | input | 2 | Address-space mode |
| req_xlate_en | input | 1 | Translation enable |
| busy | output | 1 | A walk or an untaken response is outstanding |
| cr_primary | input | 64 | Primary-space descriptor |
| cr_secondary | input | 64 | Secondary-space descriptor |
| cr_home | input | 64 | Home-space descriptor |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_fault | output | 3 | 0 none, 1 specification, 2 segment, 3 page, 4 protection, 5 bad mode |
| rsp_real_addr | output | 64 | Page-aligned real address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_exc_word | output | 64 | Exception word on a fault |

## Verification
The bench walks every descriptor depth. It seeds tables whose entries are invalid and also carry the wrong type, so a design that checks the type before the invalid bit returns fault 1 instead of 2. A segment origin with bit 11 set catches a walker that masks segment origins to 4 KiB, because that walker reads the wrong page entry. In secondary mode the bench sends both a fetch and data accesses, so a walker that uses the wrong space reads an empty table, and one that drops the permission split reports the wrong permissions. The bench also stalls the memory port and the response port, and the bypass, real-space and range-fault cases count memory reads, so a walker that starts reading too early is exposed.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int VA_W           = 64;
  localparam int PG_SHIFT       = 12;
  localparam int VPN_W          = VA_W - PG_SHIFT;
  localparam int TBL_IDX_W      = 11;
  localparam int PT_IDX_W       = 8;
  localparam int ENT_BYTES_LOG2 = 3;
  localparam int N_TBL_KINDS    = 4;
  localparam int TYPE_LO        = 2;
  localparam int REAL_BIT       = 5;
  localparam int TINV_BIT       = 5;
  localparam int PINV_BIT       = 10;
  localparam int PRO_BIT        = 9;
  localparam int SEG_ORG_LO     = 11;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_TSPEC = 3'd1,
    FLT_SEGX  = 3'd2,
    FLT_PAGEX = 3'd3,
    FLT_PROT  = 3'd4,
    FLT_MODE  = 3'd5
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] MODE_PRI  = 2'b00;
  localparam logic [1:0] MODE_SEC  = 2'b10;
  localparam logic [1:0] MODE_HOME = 2'b11;

  localparam logic [2:0] LVL_PAGE = 3'd4;
endpackage

// File: rtl/pwt_space_sel.sv
module pwt_space_sel
  import pwt_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic [1:0]      acc,
  input  logic [VA_W-1:0] cr_pri,
  input  logic [VA_W-1:0] cr_sec,
  input  logic [VA_W-1:0] cr_hom,
  output logic [VA_W-1:0] desig,
  output logic [1:0]      space_code,
  output logic            mode_bad
);
  always_comb begin
    desig      = cr_pri;
    space_code = 2'd1;
    mode_bad   = 1'b0;
    unique case (mode)
      MODE_PRI: ;
      MODE_SEC: begin
        if (acc != ACC_FETCH) begin
          desig      = cr_sec;
          space_code = 2'd2;
        end
      end
      MODE_HOME: begin
        desig      = cr_hom;
        space_code = 2'd3;
      end
      default: begin
        space_code = 2'd0;
        mode_bad   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pwt_range_chk.sv
module pwt_range_chk
  import pwt_pkg::*;
(
  input  logic [1:0]       top_type,
  input  logic [VPN_W-1:0] vpn,
  output logic             in_range
);
  localparam int SEG_LO = PT_IDX_W + TBL_IDX_W;
  localparam int RT3_LO = PT_IDX_W + 2 * TBL_IDX_W;
  localparam int RT2_LO = PT_IDX_W + 3 * TBL_IDX_W;

  always_comb begin
    unique case (top_type)
      2'd3: in_range = 1'b1;
      2'd2: in_range = (vpn[VPN_W-1:RT2_LO] == '0);
      2'd1: in_range = (vpn[VPN_W-1:RT3_LO] == '0);
      default: in_range = (vpn[VPN_W-1:SEG_LO] == '0);
    endcase
  end
endmodule

// File: rtl/pwt_index.sv
module pwt_index
  import pwt_pkg::*;
(
  input  logic [VPN_W-1:0] vpn,
  input  logic [2:0]       lvl,
  input  logic [VA_W-1:0]  origin,
  output logic [VA_W-1:0]  addr
);
  logic [VA_W-1:0] offs [N_TBL_KINDS+1];

  for (genvar k = 0; k < N_TBL_KINDS; k++) begin : g_tbl
    localparam int LO = PT_IDX_W + k * TBL_IDX_W;
    assign offs[k] = VA_W'({vpn[LO +: TBL_IDX_W], {ENT_BYTES_LOG2{1'b0}}});
  end
  assign offs[N_TBL_KINDS] = VA_W'({vpn[PT_IDX_W-1:0], {ENT_BYTES_LOG2{1'b0}}});

  always_comb begin
    if (lvl <= LVL_PAGE) addr = origin + offs[lvl];
    else                 addr = origin;
  end
endmodule

// File: rtl/pwt_perm.sv
module pwt_perm
  import pwt_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] acc,
  input  logic       ro,
  output logic [2:0] perm,
  output logic       prot_hit
);
  always_comb begin
    prot_hit = (acc == ACC_WRITE) && ro;
    perm     = {1'b1, ~ro, 1'b1};
    if (mode == MODE_SEC) begin
      if (acc == ACC_FETCH) perm = 3'b001;
      else                  perm[0] = 1'b0;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pwt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_va,
  input  logic [1:0]      req_acc,
  input  logic [1:0]      req_mode,
  input  logic            req_xlate_en,
  output logic            busy,
  input  logic [63:0]     cr_primary,
  input  logic [63:0]     cr_secondary,
  input  logic [63:0]     cr_home,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [63:0]     mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2:0]      rsp_fault,
  output logic [63:0]     rsp_real_addr,
  output logic            rsp_rd,
  output logic            rsp_wr,
  output logic            rsp_ex,
  output logic [63:0]     rsp_exc_word
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_ISSUE, S_WAIT, S_RESP} st_e;

  st_e              st;
  logic [VPN_W-1:0] vpn_q;
  logic [1:0]       acc_q, mode_q;
  logic             en_q;
  logic [2:0]       lvl_q;
  logic [VA_W-1:0]  org_q;
  fault_e           flt_q;
  logic [VA_W-1:0]  ra_q, exc_q;
  logic [2:0]       perm_q;

  logic [VA_W-1:0]  va_pg, desig, exc_base;
  logic [1:0]       space_code;
  logic             mode_bad, rng_ok, ro_sel, prot_hit;
  logic [2:0]       perm;

  logic             fin, adv;
  fault_e           fin_flt;
  logic [VA_W-1:0]  fin_ra, fin_exc, nxt_org;
  logic [2:0]       fin_perm, nxt_lvl;

  assign va_pg    = {vpn_q, {PG_SHIFT{1'b0}}};
  assign exc_base = va_pg | VA_W'(space_code);
  assign ro_sel   = (st == S_WAIT) ? mem_rsp_data[PRO_BIT] : 1'b0;

  pwt_space_sel u_sel (
    .mode(mode_q), .acc(acc_q), .cr_pri(cr_primary), .cr_sec(cr_secondary),
    .cr_hom(cr_home), .desig(desig), .space_code(space_code), .mode_bad(mode_bad)
  );

  pwt_range_chk u_rng (
    .top_type(desig[TYPE_LO +: 2]), .vpn(vpn_q), .in_range(rng_ok)
  );

  pwt_index u_idx (
    .vpn(vpn_q), .lvl(lvl_q), .origin(org_q), .addr(mem_rd_addr)
  );

  pwt_perm u_perm (
    .mode(mode_q), .acc(acc_q), .ro(ro_sel), .perm(perm), .prot_hit(prot_hit)
  );

  // Decision logic for the start step and for each returned entry
  always_comb begin
    fin      = 1'b0;
    adv      = 1'b0;
    fin_flt  = FLT_NONE;
    fin_ra   = '0;
    fin_exc  = '0;
    fin_perm = '0;
    nxt_lvl  = lvl_q;
    nxt_org  = org_q;
    if (st == S_START) begin
      if (!en_q) begin
        fin      = 1'b1;
        fin_ra   = va_pg;
        fin_perm = 3'b111;
      end else if (mode_bad) begin
        fin     = 1'b1;
        fin_flt = FLT_MODE;
        fin_exc = va_pg;
      end else if (!rng_ok) begin
        fin     = 1'b1;
        fin_flt = FLT_TSPEC;
        fin_exc = exc_base;
      end else if (desig[REAL_BIT]) begin
        fin      = 1'b1;
        fin_ra   = va_pg;
        fin_perm = perm;
      end else begin
        adv     = 1'b1;
        nxt_lvl = {1'b0, desig[TYPE_LO +: 2]};
        nxt_org = {desig[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
      end
    end else if (st == S_WAIT && mem_rsp_valid) begin
      if (lvl_q != LVL_PAGE) begin
        if (mem_rsp_data[TINV_BIT]) begin
          fin     = 1'b1;
          fin_flt = FLT_SEGX;
          fin_exc = exc_base;
        end else if (mem_rsp_data[TYPE_LO +: 2] != lvl_q[1:0]) begin
          fin     = 1'b1;
          fin_flt = FLT_TSPEC;
          fin_exc = exc_base;
        end else if (lvl_q == 3'd0) begin
          adv     = 1'b1;
          nxt_lvl = LVL_PAGE;
          nxt_org = {mem_rsp_data[VA_W-1:SEG_ORG_LO], {SEG_ORG_LO{1'b0}}};
        end else begin
          adv     = 1'b1;
          nxt_lvl = lvl_q - 3'd1;
          nxt_org = {mem_rsp_data[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
        end
      end else if (mem_rsp_data[PINV_BIT]) begin
        fin     = 1'b1;
        fin_flt = FLT_PAGEX;
        fin_exc = exc_base;
      end else if (prot_hit) begin
        fin     = 1'b1;
        fin_flt = FLT_PROT;
        fin_exc = exc_base | VA_W'(4);
      end else begin
        fin      = 1'b1;
        fin_ra   = {mem_rsp_data[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
        fin_perm = perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      vpn_q  <= '0;
      acc_q  <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
      lvl_q  <= '0;
      org_q  <= '0;
      flt_q  <= FLT_NONE;
      ra_q   <= '0;
      exc_q  <= '0;
      perm_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            vpn_q  <= req_va[VA_W-1:PG_SHIFT];
            acc_q  <= req_acc;
            mode_q <= req_mode;
            en_q   <= req_xlate_en;
            st     <= S_START;
          end
        end
        S_START, S_WAIT: begin
          if (fin) begin
            flt_q  <= fin_flt;
            ra_q   <= fin_ra;
            exc_q  <= fin_exc;
            perm_q <= fin_perm;
            st     <= S_RESP;
          end else if (adv) begin
            lvl_q <= nxt_lvl;
            org_q <= nxt_org;
            st    <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_rd_ready) st <= S_WAIT;
        S_RESP:  if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign busy          = (st != S_IDLE);
  assign mem_rd_valid  = (st == S_ISSUE);
  assign rsp_valid     = (st == S_RESP);
  assign rsp_fault     = flt_q;
  assign rsp_real_addr = ra_q;
  assign rsp_exc_word  = exc_q;
  assign {rsp_rd, rsp_wr, rsp_ex} = perm_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [63:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_fault,
  input logic [63:0] rsp_real_addr,
  input logic        rsp_rd,
  input logic        rsp_wr,
  input logic        rsp_ex,
  input logic [63:0] rsp_exc_word
);
  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready)); // R1
  AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R1
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) &&
      $stable(rsp_real_addr) && $stable(rsp_exc_word)); // R1
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R13
  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[2:0] == 3'd0); // R13
  AST_RA_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_real_addr[11:0] == 12'd0); // R9
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> !rsp_rd && !rsp_wr && !rsp_ex &&
      rsp_real_addr == 64'd0); // R12
  AST_PROT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd4 |-> rsp_exc_word[2]); // R11
  AST_OK_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd0 |-> rsp_exc_word == 64'd0); // R12
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_fault(rsp_fault), .rsp_real_addr(rsp_real_addr), .rsp_rd(rsp_rd),
  .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_exc_word(rsp_exc_word)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_xlate_en, busy;
  logic [63:0] req_va;
  logic [1:0]  req_acc, req_mode;
  logic [63:0] cr_primary, cr_secondary, cr_home;
  logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [63:0] mem_rd_addr, mem_rsp_data;
  logic        rsp_valid, rsp_ready, rsp_rd, rsp_wr, rsp_ex;
  logic [2:0]  rsp_fault;
  logic [63:0] rsp_real_addr, rsp_exc_word;

  logic [63:0] mem [logic [63:0]];
  int          n_checks = 0;
  int          n_fail   = 0;
  int          rd_count = 0;
  int          stall    = 0;

  logic [2:0]  r_flt;
  logic [63:0] r_ra, r_exc;
  logic [2:0]  r_perm;
  int          r_reads;

  localparam logic [63:0] CR_SEG = 64'h10000;
  localparam logic [63:0] CR_RT2 = 64'h90000 | 64'h8;
  localparam logic [63:0] CR_RT1 = 64'h40000 | 64'hC;
  localparam logic [63:0] VA_R1  = (64'd1 << 53) | (64'd2 << 42) | (64'd3 << 31) |
                                   (64'd4 << 20) | (64'd5 << 12) | 64'h9ab;

  pt_walker dut (.*);

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  // memory model: optional stall, one-cycle ready, data one cycle later
  initial begin
    mem_rd_ready  = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        logic [63:0] a;
        a = mem_rd_addr;
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          chk(mem_rd_valid && mem_rd_addr == a, "R13 read held during stall",
              mem_rd_addr, a);
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(a) ? mem[a] : 64'd0;
        rd_count++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_xl(input logic [63:0] va, input logic [1:0] acc,
                        input logic [1:0] mode, input logic en, input int hold);
    rd_count = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_mode = mode; req_xlate_en = en;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R1 busy after accept", {62'd0, busy, req_ready}, 64'd2);
    while (!rsp_valid) @(negedge clk);
    r_flt = rsp_fault; r_ra = rsp_real_addr; r_exc = rsp_exc_word;
    r_perm = {rsp_rd, rsp_wr, rsp_ex}; r_reads = rd_count;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_fault == r_flt && rsp_real_addr == r_ra &&
          rsp_exc_word == r_exc, "R1 response held", rsp_real_addr, r_ra);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!busy && req_ready && !rsp_valid, "R1 idle after take",
        {61'd0, busy, req_ready, rsp_valid}, 64'd2);
  endtask

  task automatic exp_ok(input string tag, input logic [63:0] ra, input logic [2:0] perm,
                        input int reads);
    chk(r_flt == 3'd0, tag, 64'(r_flt), 64'd0);
    chk(r_ra == ra, tag, r_ra, ra);
    chk(r_perm == perm, tag, 64'(r_perm), 64'(perm));
    chk(r_exc == 64'd0, tag, r_exc, 64'd0);
    chk(r_reads == reads, tag, 64'(r_reads), 64'(reads));
  endtask

  task automatic exp_flt(input string tag, input logic [2:0] code, input logic [63:0] exc,
                         input int reads);
    chk(r_flt == code, tag, 64'(r_flt), 64'(code));
    chk(r_exc == exc, tag, r_exc, exc);
    chk(r_ra == 64'd0 && r_perm == 3'd0, tag, r_ra, 64'd0);
    chk(r_reads == reads, tag, 64'(r_reads), 64'(reads));
  endtask

  task automatic t_reset();
    chk(req_ready && !busy && !rsp_valid && !mem_rd_valid, "R1 reset state",
        {60'd0, req_ready, busy, rsp_valid, mem_rd_valid}, 64'd8);
  endtask

  task automatic t_bypass();
    run_xl(64'hFFFF_0000_0000_0FFF, 2'd1, 2'b01, 1'b0, 0);
    exp_ok("R2 translation off", 64'hFFFF_0000_0000_0000, 3'b111, 0);
  endtask

  task automatic t_bad_mode();
    run_xl(64'h3abc, 2'd0, 2'b01, 1'b1, 0);
    exp_flt("R3 illegal mode", 3'd5, 64'h3000, 0);
  endtask

  task automatic t_segment_top();
    run_xl(64'h1234_5678, 2'd0, 2'b00, 1'b1, 0);
    exp_ok("R6 segment-top read", 64'hABCDE000, 3'b111, 2);
    run_xl(64'h1234_5678, 2'd1, 2'b00, 1'b1, 0);
    exp_ok("R9 writable page write", 64'hABCDE000, 3'b111, 2);
    run_xl(64'h1234_6000, 2'd0, 2'b00, 1'b1, 0);
    exp_flt("R9 page invalid", 3'd3, 64'h1234_6001, 2);
    run_xl(64'h1240_0000, 2'd0, 2'b00, 1'b1, 0);
    exp_flt("R7 segment entry invalid", 3'd2, 64'h1240_0001, 1);
  endtask

  task automatic t_region1_top();
    run_xl(VA_R1, 2'd0, 2'b11, 1'b1, 0);
    exp_ok("R8 five-level walk read-only page", 64'h12345000, 3'b101, 5);
    run_xl(VA_R1, 2'd3, 2'b11, 1'b1, 0);
    exp_ok("R12 access code 3 acts as read", 64'h12345000, 3'b101, 5);
    run_xl(VA_R1, 2'd1, 2'b11, 1'b1, 0);
    exp_flt("R11 protection fault", 3'd4, (VA_R1 & ~64'hFFF) | 64'h7, 5);
  endtask

  task automatic t_secondary();
    run_xl(64'h1234_5678, 2'd2, 2'b10, 1'b1, 0);
    exp_ok("R10 secondary fetch via primary", 64'hABCDE000, 3'b001, 2);
    run_xl(64'd3 << 42, 2'd0, 2'b10, 1'b1, 0);
    exp_ok("R10 secondary data read", 64'h777000, 3'b110, 4);
    run_xl(64'd1 << 42, 2'd0, 2'b10, 1'b1, 0);
    exp_flt("R7 entry type mismatch", 3'd1, (64'd1 << 42) | 64'd2, 1);
    run_xl(64'd2 << 42, 2'd0, 2'b10, 1'b1, 0);
    exp_flt("R7 invalid before type", 3'd2, (64'd2 << 42) | 64'd2, 1);
  endtask

  task automatic t_range();
    run_xl(64'h8000_0000, 2'd0, 2'b00, 1'b1, 0);
    exp_flt("R4 segment-top range", 3'd1, 64'h8000_0001, 0);
    run_xl(64'd1 << 53, 2'd0, 2'b10, 1'b1, 0);
    exp_flt("R4 type-2 range", 3'd1, (64'd1 << 53) | 64'd2, 0);
    @(negedge clk);
    cr_home = 64'h60000 | 64'h4;
    run_xl(64'd1 << 42, 2'd0, 2'b11, 1'b1, 0);
    exp_flt("R4 type-1 range", 3'd1, (64'd1 << 42) | 64'd3, 0);
    @(negedge clk);
    cr_home = CR_RT1;
  endtask

  task automatic t_real_space();
    @(negedge clk);
    cr_primary = CR_SEG | 64'h20;
    run_xl(64'h5555_1234, 2'd1, 2'b00, 1'b1, 0);
    exp_ok("R5 real-space descriptor", 64'h5555_1000, 3'b111, 0);
    @(negedge clk);
    cr_primary = CR_SEG;
  endtask

  task automatic t_backpressure();
    stall = 2;
    run_xl(64'd3 << 42, 2'd1, 2'b10, 1'b1, 3);
    exp_ok("R13 stalled walk with held response", 64'h777000, 3'b110, 4);
    stall = 0;
  endtask

  initial begin
    // segment-top primary space
    mem[64'h10918] = 64'h20000;
    mem[64'h20228] = 64'hABCDE000;
    mem[64'h20230] = 64'h400;
    mem[64'h10920] = 64'h20;
    // type-3 top, home space
    mem[64'h40008] = 64'h50000 | 64'hC;
    mem[64'h50010] = 64'h60000 | 64'h8;
    mem[64'h60018] = 64'h70000 | 64'h4;
    mem[64'h70020] = 64'h80800;
    mem[64'h80828] = 64'h12345000 | 64'h200;
    // type-2 top, secondary space
    mem[64'h90018] = 64'hA0000 | 64'h8;
    mem[64'hA0000] = 64'hB0000 | 64'h4;
    mem[64'hB0000] = 64'hC0000;
    mem[64'hC0000] = 64'h777000;
    mem[64'h90008] = 64'hA0000 | 64'hC;
    mem[64'h90010] = 64'hA0000 | 64'h2C;

    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
    req_va = '0; req_acc = '0; req_mode = '0; req_xlate_en = 1'b0;
    cr_primary = CR_SEG; cr_secondary = CR_RT2; cr_home = CR_RT1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_bad_mode();
    t_segment_top();
    t_region1_top();
    t_secondary();
    t_range();
    t_real_space();
    t_backpressure();
    finish_run();
  end
endmodule